// File: doc/BRIEF.md
# Supply Supervisor with Bus-Kicked Watchdog

This block turns already-digitized supply comparator decisions into the system-level control signals of a board supervisor. It produces an active-low system reset, a low-line flag, a secondary-supply fail flag, an active-low watchdog pulse and a battery-select level. All durations are counted in ticks of a one-millisecond enable input, `tick_ms`. Every duration is a parameter, so a bench can shrink them.

The reset sequencer has three states: `RS_HELD`, `RS_TIMING` and `RS_RELEASED`. It moves from HELD to TIMING when no reset cause remains. It moves from TIMING to RELEASED once the hold count elapses, and from TIMING back to HELD if a cause returns. It moves from RELEASED to HELD on any new cause. A cause is either a primary supply below trip or a debounced manual press.

The bus monitor has two states. It moves from `BUS_IDLE` to `BUS_ARMED` on a START. It moves from ARMED back to IDLE on the next SCL fall, which kicks the watchdog.

The watchdog has three states. It moves from `WD_IDLE` to `WD_COUNT` when it is enabled and not frozen. It moves from COUNT to `WD_BITE` at timeout, and from BITE back to COUNT when the pulse ends. It returns to IDLE from any state when it is disabled or frozen.

The power selector has two states. It moves from `PW_MAIN` to `PW_BACKUP` when the supply is below trip and below the battery minus hysteresis. It moves from BACKUP back to MAIN when the supply is back above trip or above the battery plus hysteresis.

Top module: `supply_guard`

## Requirements
- R1: `lowline_n` equals `pri_ok` in the same cycle, with no register and no delay.
- R2: `sec_fail_n` equals `sec_ok` in the same cycle, with no power-up delay.
- R3: `rst_out_n` is low from the clock edge after `pri_ok` is sampled low. After the last cause clears, it goes high once HOLD_SHORT ticks have been counted in `RS_TIMING`.
- R4: With `hold_long`=1 the hold is HOLD_LONG ticks, and with `hold_long`=0 it is HOLD_SHORT ticks. The short hold applies after power-on with the bit at 0.
- R5: A manual press counts only after `mr_n` has been sampled low on DEB_TICKS consecutive ticks. Any high sample cancels the press. Reset stays low while the press lasts and for the hold time after release. A shorter low pulse leaves `rst_out_n` high.
- R6: A START is SDA falling while SCL is high, seen after a two-flop synchronizer. The first synchronized SCL fall after a START restarts the watchdog count. SCL falls without a preceding START do not restart it.
- R7: `wd_sel` selects the timeout: 2'b00 = WD_T00 ticks (800 by default), 2'b01 = WD_T01 (400), 2'b10 = WD_T10 (150), 2'b11 = disabled. When disabled, `wdo_n` stays high.
- R8: At timeout `wdo_n` goes low for BITE_TICKS ticks, then returns high and the count restarts from zero.
- R9: `batt_on` rises when `pri_ok`=0 and `sup_below_bat`=1. It falls when `pri_ok`=1 or `sup_above_bat`=1. Between the two hysteresis flags it keeps its state.
- R10: While `batt_on` is high, the watchdog is held in `WD_IDLE` with its count cleared and `wdo_n` high. A full period restarts when `batt_on` falls.
- R11: During `rst_n` low, `rst_out_n`=0, `wdo_n`=1 and `batt_on`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| tick_ms | input | 1 | One-cycle enable per millisecond |
| pri_ok | input | 1 | Primary supply above its trip level |
| sec_ok | input | 1 | Secondary monitor above its trip level |
| sup_above_bat | input | 1 | Supply above battery plus hysteresis |
| sup_below_bat | input | 1 | Supply below battery minus hysteresis |
| mr_n | input | 1 | Manual reset, active low, synchronous to clk |
| scl | input | 1 | Serial bus clock line, monitored only |
| sda | input | 1 | Serial bus data line, monitored only |
| wd_sel | input | 2 | Watchdog timeout select |
| hold_long | input | 1 | Reset hold select, 1 = long |
| rst_out_n | output | 1 | System reset, active low |
| lowline_n | output | 1 | Primary low flag, active low |
| sec_fail_n | output | 1 | Secondary fail flag, active low |
| wdo_n | output | 1 | Watchdog pulse, active low |
| batt_on | output | 1 | High while running from battery |

## Verification
The bench goes after these corner cases:

- **Hold length (R3, R4).** The hold is measured exactly in ticks under both settings of `hold_long`. A counter that is off by one, or that ignores the bit, shows up as `rst_out_n` moving one tick early, one tick late, or after the wrong hold.
- **Short manual pulse (R5).** The bench drives a manual pulse shorter than the debounce window. A design that skips the debounce would drop reset on this glitch.
- **Kicks without a START (R6).** The bench toggles SCL with no START in front. A design that kicks on every SCL fall never fires during this stretch, while a design that ignores kicks fires during the kicked stretch.
- **Battery hysteresis and freeze (R9, R10).** The bench holds the supply between the two hysteresis flags and keeps the block in backup over a period. A design that switches on a single flag would chatter out of backup. A watchdog that keeps counting in backup would pulse `wdo_n`.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [1:0] {RS_HELD, RS_TIMING, RS_RELEASED} rs_state_t;
    typedef enum logic [1:0] {WD_IDLE, WD_COUNT, WD_BITE} wd_state_t;
    typedef enum logic {PW_MAIN, PW_BACKUP} pw_state_t;
    typedef enum logic {BUS_IDLE, BUS_ARMED} bus_state_t;
    localparam logic [1:0] WD_SEL_OFF = 2'b11;
endpackage

// File: rtl/sg_bus_kick.sv
module sg_bus_kick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic kick
);
    import sg_pkg::*;

    logic [1:0] raw;
    logic [1:0] now_s;
    logic [1:0] prev_s;
    bus_state_t st, st_nxt;
    logic start_seen, scl_fall;

    assign raw = {sda, scl};

    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[ln]};
        end
        assign now_s[ln] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_s <= 2'b11;
        else        prev_s <= now_s;
    end

    assign start_seen = prev_s[0] && now_s[0] && prev_s[1] && !now_s[1];
    assign scl_fall   = prev_s[0] && !now_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BUS_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            BUS_IDLE:  if (start_seen) st_nxt = BUS_ARMED;
            BUS_ARMED: if (scl_fall)   st_nxt = BUS_IDLE;
            default:   st_nxt = BUS_IDLE;
        endcase
    end

    always_comb begin
        kick = (st == BUS_ARMED) && scl_fall;
    end

    // R6: a kick is always followed by the disarmed state
    a_r6_disarm_after_kick: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st == BUS_IDLE));
endmodule

// File: rtl/sg_reset_seq.sv
module sg_reset_seq #(
    parameter int HOLD_SHORT = 150,
    parameter int HOLD_LONG  = 800,
    parameter int DEB_TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic pri_ok,
    input  logic mr_n,
    input  logic hold_long,
    output logic rst_out_n
);
    import sg_pkg::*;

    localparam int HW = $clog2(HOLD_LONG + 1);
    localparam int DW = $clog2(DEB_TICKS + 1);
    localparam logic [HW-1:0] LIM_S = HW'(HOLD_SHORT - 1);
    localparam logic [HW-1:0] LIM_L = HW'(HOLD_LONG - 1);
    localparam logic [DW-1:0] DEB_L = DW'(DEB_TICKS);

    logic [DW-1:0] dcnt;
    logic          pressed;
    logic [HW-1:0] hcnt;
    logic [HW-1:0] lim;
    logic          cause;
    logic          done;
    rs_state_t     st, st_nxt;

    // manual press debounce: consecutive low ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          dcnt <= '0;
        else if (mr_n)                       dcnt <= '0;
        else if (tick_ms && dcnt != DEB_L)   dcnt <= dcnt + DW'(1);
    end

    assign pressed = (dcnt == DEB_L);
    assign cause   = !pri_ok || pressed;
    assign lim     = hold_long ? LIM_L : LIM_S;
    assign done    = tick_ms && (hcnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RS_HELD;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RS_HELD:     if (!cause) st_nxt = RS_TIMING;
            RS_TIMING:   if (cause) st_nxt = RS_HELD;
                         else if (done) st_nxt = RS_RELEASED;
            RS_RELEASED: if (cause) st_nxt = RS_HELD;
            default:     st_nxt = RS_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hcnt <= '0;
        else if (st != RS_TIMING || cause || done) hcnt <= '0;
        else if (tick_ms)                        hcnt <= hcnt + HW'(1);
    end

    always_comb begin
        rst_out_n = (st == RS_RELEASED);
    end

    a_r3_low_on_bad_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_ok |=> !rst_out_n);
    a_r3_release_from_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(st == RS_TIMING));
    a_r5_press_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pressed) |-> !$past(mr_n));
endmodule

// File: rtl/sg_watchdog.sv
module sg_watchdog #(
    parameter int WD_T00     = 800,
    parameter int WD_T01     = 400,
    parameter int WD_T10     = 150,
    parameter int BITE_TICKS = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic [1:0] wd_sel,
    input  logic       kick,
    input  logic       freeze,
    output logic       wdo_n
);
    import sg_pkg::*;

    localparam int M1 = (WD_T00 > WD_T01) ? WD_T00 : WD_T01;
    localparam int M2 = (M1 > WD_T10) ? M1 : WD_T10;
    localparam int MX = (M2 > BITE_TICKS) ? M2 : BITE_TICKS;
    localparam int WW = $clog2(MX + 1);
    localparam logic [WW-1:0] L00 = WW'(WD_T00 - 1);
    localparam logic [WW-1:0] L01 = WW'(WD_T01 - 1);
    localparam logic [WW-1:0] L10 = WW'(WD_T10 - 1);
    localparam logic [WW-1:0] LB  = WW'(BITE_TICKS - 1);

    wd_state_t     st, st_nxt;
    logic [WW-1:0] wcnt;
    logic [WW-1:0] per_lim;
    logic          enabled;
    logic          hold_off;
    logic          timeout;
    logic          bite_end;

    always_comb begin
        unique case (wd_sel)
            2'b00:   per_lim = L00;
            2'b01:   per_lim = L01;
            2'b10:   per_lim = L10;
            default: per_lim = '0;
        endcase
    end

    assign enabled  = (wd_sel != WD_SEL_OFF);
    assign hold_off = freeze || !enabled;
    assign timeout  = !kick && tick_ms && (wcnt >= per_lim);
    assign bite_end = tick_ms && (wcnt >= LB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (hold_off) begin
            st_nxt = WD_IDLE;
        end else begin
            unique case (st)
                WD_IDLE:  st_nxt = WD_COUNT;
                WD_COUNT: if (timeout) st_nxt = WD_BITE;
                WD_BITE:  if (bite_end) st_nxt = WD_COUNT;
                default:  st_nxt = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (hold_off || st == WD_IDLE) begin
            wcnt <= '0;
        end else if (st == WD_COUNT) begin
            if (kick || timeout) wcnt <= '0;
            else if (tick_ms)    wcnt <= wcnt + WW'(1);
        end else begin
            if (bite_end)        wcnt <= '0;
            else if (tick_ms)    wcnt <= wcnt + WW'(1);
        end
    end

    always_comb begin
        wdo_n = (st != WD_BITE);
    end

    a_r10_quiet_in_backup: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> wdo_n);
    a_r8_bite_from_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> $past(st == WD_COUNT));
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == WD_SEL_OFF) |=> wdo_n);
endmodule

// File: rtl/sg_power_sel.sv
module sg_power_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_ok,
    input  logic sup_above_bat,
    input  logic sup_below_bat,
    output logic batt_on
);
    import sg_pkg::*;

    pw_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PW_MAIN;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            PW_MAIN:   if (!pri_ok && sup_below_bat) st_nxt = PW_BACKUP;
            PW_BACKUP: if (pri_ok || sup_above_bat)  st_nxt = PW_MAIN;
            default:   st_nxt = PW_MAIN;
        endcase
    end

    always_comb begin
        batt_on = (st == PW_BACKUP);
    end

    a_r9_main_when_supply_good: assert property (@(posedge clk) disable iff (!rst_n)
        pri_ok |=> !batt_on);
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
    parameter int HOLD_SHORT  = 150,
    parameter int HOLD_LONG   = 800,
    parameter int DEB_TICKS   = 16,
    parameter int WD_T00      = 800,
    parameter int WD_T01      = 400,
    parameter int WD_T10      = 150,
    parameter int BITE_TICKS  = 150,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       pri_ok,
    input  logic       sec_ok,
    input  logic       sup_above_bat,
    input  logic       sup_below_bat,
    input  logic       mr_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [1:0] wd_sel,
    input  logic       hold_long,
    output logic       rst_out_n,
    output logic       lowline_n,
    output logic       sec_fail_n,
    output logic       wdo_n,
    output logic       batt_on
);
    logic kick;

    assign lowline_n  = pri_ok;
    assign sec_fail_n = sec_ok;

    sg_bus_kick #(.STAGES(SYNC_STAGES)) u_bus (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .kick(kick));

    sg_reset_seq #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG),
                   .DEB_TICKS(DEB_TICKS)) u_rst (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pri_ok(pri_ok),
        .mr_n(mr_n), .hold_long(hold_long), .rst_out_n(rst_out_n));

    sg_power_sel u_pwr (
        .clk(clk), .rst_n(rst_n), .pri_ok(pri_ok),
        .sup_above_bat(sup_above_bat), .sup_below_bat(sup_below_bat),
        .batt_on(batt_on));

    sg_watchdog #(.WD_T00(WD_T00), .WD_T01(WD_T01), .WD_T10(WD_T10),
                  .BITE_TICKS(BITE_TICKS)) u_wd (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wd_sel(wd_sel),
        .kick(kick), .freeze(batt_on), .wdo_n(wdo_n));

    // R1 and R2: the flags are plain wires from the comparators
    a_r1_lowline_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lowline_n == pri_ok);
endmodule

// File: tb/supply_guard_test.sv
module supply_guard_test;
    localparam int HS = 12, HL = 30, DEB = 4;
    localparam int T00 = 40, T01 = 25, T10 = 16, BT = 6;

    logic clk = 1'b0;
    logic rst_n, tick_ms, pri_ok, sec_ok, sup_above_bat, sup_below_bat;
    logic mr_n, scl, sda, hold_long;
    logic [1:0] wd_sel;
    logic rst_out_n, lowline_n, sec_fail_n, wdo_n, batt_on;

    int checks = 0, errs = 0, falls = 0;
    bit cmp_en = 0, finished = 0;
    string phase = "R11";

    always #2.5 clk = ~clk;

    supply_guard #(.HOLD_SHORT(HS), .HOLD_LONG(HL), .DEB_TICKS(DEB),
                   .WD_T00(T00), .WD_T01(T01), .WD_T10(T10),
                   .BITE_TICKS(BT), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pri_ok(pri_ok),
        .sec_ok(sec_ok), .sup_above_bat(sup_above_bat),
        .sup_below_bat(sup_below_bat), .mr_n(mr_n), .scl(scl), .sda(sda),
        .wd_sel(wd_sel), .hold_long(hold_long), .rst_out_n(rst_out_n),
        .lowline_n(lowline_n), .sec_fail_n(sec_fail_n), .wdo_n(wdo_n),
        .batt_on(batt_on));

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s (%s) at %0t: got %0b expected %0b", tag, phase, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_rs, m_rc, m_dc, m_ws, m_wc, m_bat, m_arm;
    int s1c, s2c, qc, s1d, s2d, qd;
    always @(posedge clk) begin
        int lim, per;
        bit kk, st, cause;
        if (!rst_n) begin
            m_rs = 0; m_rc = 0; m_dc = 0; m_ws = 0; m_wc = 0; m_bat = 0; m_arm = 0;
            s1c = 1; s2c = 1; qc = 1; s1d = 1; s2d = 1; qd = 1;
        end else begin
            kk = (m_arm == 1) && qc == 1 && s2c == 0;
            st = qc == 1 && s2c == 1 && qd == 1 && s2d == 0;
            if (st) m_arm = 1; else if (kk) m_arm = 0;
            qc = s2c; s2c = s1c; s1c = scl;
            qd = s2d; s2d = s1d; s1d = sda;
            cause = !pri_ok || (m_dc == DEB);
            lim = hold_long ? HL : HS;
            case (m_rs)
                0: if (!cause) begin m_rs = 1; m_rc = 0; end
                1: if (cause) begin m_rs = 0; m_rc = 0; end
                   else if (tick_ms) begin
                       if (m_rc >= lim - 1) begin m_rs = 2; m_rc = 0; end
                       else m_rc++;
                   end
                default: if (cause) m_rs = 0;
            endcase
            if (mr_n) m_dc = 0; else if (tick_ms && m_dc < DEB) m_dc++;
            per = (wd_sel == 2'b00) ? T00 : (wd_sel == 2'b01) ? T01 : T10;
            if (m_bat == 1 || wd_sel == 2'b11) begin m_ws = 0; m_wc = 0; end
            else case (m_ws)
                0: begin m_ws = 1; m_wc = 0; end
                1: if (kk) m_wc = 0;
                   else if (tick_ms) begin
                       if (m_wc >= per - 1) begin m_ws = 2; m_wc = 0; end
                       else m_wc++;
                   end
                default: if (tick_ms) begin
                       if (m_wc >= BT - 1) begin m_ws = 1; m_wc = 0; end
                       else m_wc++;
                   end
            endcase
            if (m_bat == 0) begin if (!pri_ok && sup_below_bat) m_bat = 1; end
            else if (pri_ok || sup_above_bat) m_bat = 0;
        end
    end

    // every-clock comparison, 1 ns after the edge
    initial begin
        bit prev = 1;
        forever begin
            @(posedge clk); #1;
            if (cmp_en) begin
                check("R1 lowline_n", lowline_n, pri_ok);
                check("R2 sec_fail_n", sec_fail_n, sec_ok);
                check("R3 rst_out_n", rst_out_n, m_rs == 2);
                check("R8 wdo_n", wdo_n, m_ws != 2);
                check("R9 batt_on", batt_on, m_bat[0]);
            end
            if (prev && !wdo_n) falls++;
            prev = wdo_n;
        end
    end

    initial begin
        tick_ms = 0;
        forever begin
            repeat (3) @(negedge clk);
            tick_ms = 1;
            @(negedge clk);
            tick_ms = 0;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_kick_seq();   // START then SCL fall (R6)
        scl = 1; sda = 1; idle(3);
        sda = 0; idle(3);
        scl = 0; idle(3);
        sda = 1; idle(3);
        scl = 1; idle(3);
    endtask

    task automatic bus_plain_clock(); // SCL pulse, no START
        scl = 0; idle(3);
        scl = 1; idle(3);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int f0;
        rst_n = 0; pri_ok = 1; sec_ok = 1; sup_above_bat = 1; sup_below_bat = 0;
        mr_n = 1; scl = 1; sda = 1; hold_long = 0; wd_sel = 2'b11;
        idle(4);
        // R11: reset state
        check("R11 rst_out_n in reset", rst_out_n, 1'b0);
        check("R11 wdo_n in reset", wdo_n, 1'b1);
        check("R11 batt_on in reset", batt_on, 1'b0);
        rst_n = 1; cmp_en = 1;

        phase = "R3";
        idle(100);
        check("R3 released after short hold", rst_out_n, 1'b1);
        pri_ok = 0; idle(10);
        check("R3 asserted while supply low", rst_out_n, 1'b0);
        check("R1 lowline low", lowline_n, 1'b0);
        pri_ok = 1; idle(70);
        check("R3 released again", rst_out_n, 1'b1);

        phase = "R4";
        hold_long = 1; pri_ok = 0; idle(8); pri_ok = 1;
        idle(60);
        check("R4 still held past short hold", rst_out_n, 1'b0);
        idle(130);
        check("R4 released after long hold", rst_out_n, 1'b1);
        hold_long = 0;

        phase = "R2";
        sec_ok = 0; idle(5);
        check("R2 sec fail low", sec_fail_n, 1'b0);
        sec_ok = 1; idle(5);

        phase = "R5";
        mr_n = 0; idle(8); mr_n = 1; idle(20);
        check("R5 short glitch ignored", rst_out_n, 1'b1);
        mr_n = 0; idle(40);
        check("R5 press asserts reset", rst_out_n, 1'b0);
        mr_n = 1; idle(8);
        check("R5 held after release", rst_out_n, 1'b0);
        idle(60);
        check("R5 released after hold", rst_out_n, 1'b1);

        phase = "R7";
        f0 = falls; idle(300);
        check("R7 disabled watchdog quiet", falls == f0, 1'b1);
        wd_sel = 2'b10; f0 = falls; idle(150);
        check("R8 timeout pulses wdo_n", falls > f0, 1'b1);
        wd_sel = 2'b01; idle(250);

        phase = "R6";
        wd_sel = 2'b00; bus_kick_seq(); f0 = falls;
        for (int i = 0; i < 6; i++) begin idle(70); bus_kick_seq(); end
        check("R6 START kicks keep watchdog quiet", falls == f0, 1'b1);
        f0 = falls;
        for (int i = 0; i < 40; i++) bus_plain_clock();
        check("R6 SCL without START does not kick", falls > f0, 1'b1);

        phase = "R9";
        wd_sel = 2'b01;
        pri_ok = 0; sup_above_bat = 0; sup_below_bat = 1; idle(4);
        check("R9 backup entered", batt_on, 1'b1);
        sup_below_bat = 0; idle(10);
        check("R9 hysteresis band holds backup", batt_on, 1'b1);
        phase = "R10";
        f0 = falls; idle(200);
        check("R10 watchdog frozen in backup", falls == f0, 1'b1);
        sup_above_bat = 1; idle(4);
        check("R9 leaves on supply above battery", batt_on, 1'b0);
        phase = "R9";
        sup_above_bat = 0; idle(4);
        check("R9 no entry inside band", batt_on, 1'b0);
        sup_below_bat = 1; idle(4);
        check("R9 entry below band", batt_on, 1'b1);
        pri_ok = 1; idle(4);
        check("R9 leaves on supply above trip", batt_on, 1'b0);
        phase = "R10";
        idle(150);

        cmp_en = 0; finished = 1;
        finish_run();
    end
endmodule